// File: doc/BRIEF.md
# Serial servo command receiver

This block takes one-byte commands from a host microcontroller over a three-wire serial link: an enable line, a shift clock and a data line. While enable is high, each rising edge of the shift clock captures one data bit. When enable falls, a complete byte becomes the pending command. The pending command is not applied at once. It takes effect on the next pulse of a slow internal tick, which is made by dividing the system clock.

Executed commands drive the control flags of an optical disc servo front end:
- laser enable;
- focus and tracking mute;
- sled mute;
- spindle mode;
- the focus and track offset-adjust busy flags and applied flags;
- two one-cycle start pulses, one for focus search and one for error-signal balance.

The block also holds several sequencing rules:
- A two-byte masking window makes bytes ignored until it is closed.
- The two start commands stay latched, so a bare enable pulse fires them again.
- An offset adjustment may start only after a minimum wait, counted in ticks.

Top module: `servo_cmd_rx`

## Requirements
- R1: Data is sampled on rising edges of `cmd_sck` while `cmd_cs` is high. Bits arrive least significant bit first. A command is exactly 8 bits.
- R2: A frame whose bit count at the fall of `cmd_cs` is neither 8 nor 0 is discarded. No output changes because of it.
- R3: A command takes effect on the first internal tick after the fall of `cmd_cs` is seen. A tick occurs once every `TICK_DIV` clock cycles. Outputs change only in the cycle after a tick.
- R4: After reset, and after command 0x00, the outputs are: laser off, focus muted, tracking muted, sled muted, spindle off (`spin_mode` = 00), both offset busy and applied flags clear, masking closed, latched command cleared.
- R5: Command 0x94 sets the laser on and unmutes focus. Command 0x95 turns the laser off and unmutes focus. Command 0x96 turns the laser off and mutes focus.
- R6: Command 0x9E unmutes tracking. Command 0x9D mutes it.
- R7: Command 0x9A clears the sled-off state and command 0x9B sets it. `sled_mute` is high while the sled-off state is set or while `sled_off_in` is high.
- R8: `spin_mode` becomes 01 on 0x97 (small disc), 10 on 0x98 (large disc) and 00 on 0x99 (off). It is never 11.
- R9: Command 0x08 gives one `search_pulse` and command 0x9C gives one `bal_pulse`. Either command stays latched, and a bare enable pulse with no clock edges fires it again. Sending 0xFE clears the latch.
- R10: Bytes 0xF0 and 0xF8 open masking. While masking is open, every byte and every bare enable pulse is ignored, except 0xFF, which closes masking.
- R11: Command 0x90 (focus) or 0x92 (track) starts an offset adjustment, which sets the busy flag and the applied flag. The start is accepted only after at least `WAIT_TICKS` ticks have passed since reset, since 0x00, or since the matching off command (0x91 or 0x93). Otherwise the start is ignored.
- R12: A busy flag clears on the `BUSY_TICKS`-th tick after its start. Its applied flag stays set. The off command (0x91 or 0x93) clears both flags at once and restarts the wait.
- R13: `search_pulse` and `bal_pulse` are each exactly one clock cycle wide and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cs | input | 1 | Serial enable; a falling edge ends a frame |
| cmd_sck | input | 1 | Serial shift clock |
| cmd_sdi | input | 1 | Serial data, LSB first |
| sled_off_in | input | 1 | External sled mute request |
| laser_on | output | 1 | Laser enable |
| focus_mute | output | 1 | Focus loop muted |
| track_mute | output | 1 | Tracking loop muted |
| sled_mute | output | 1 | Sled drive muted |
| spin_mode | output | 2 | Spindle mode: 00 off, 01 small disc, 10 large disc |
| search_pulse | output | 1 | One-cycle focus search start |
| bal_pulse | output | 1 | One-cycle balance adjust start |
| focus_ofs_busy | output | 1 | Focus offset adjustment running |
| focus_ofs_on | output | 1 | Focus offset correction applied |
| track_ofs_busy | output | 1 | Track offset adjustment running |
| track_ofs_on | output | 1 | Track offset correction applied |

## Verification
The checker watches several properties on every cycle:
- outputs move only after an internal tick;
- the spindle code stays legal;
- the start pulses are single-cycle and never overlap;
- the external sled request always forces the mute;
- a busy flag never rises, or stays set, without its wait having expired.

Other behaviours depend on byte sequences, so only the bench's scenarios can show them:
- bit order;
- discarding of short and long frames;
- masking windows;
- re-firing of latched starts and their clearing by 0xFE;
- rejection of an early offset start;
- the exact tick on which a busy flag clears.

The bench's reference model covers these and is compared on every clock.

// File: rtl/servo_cmd_rx.sv
module servo_cmd_rx #(
  parameter int TICK_DIV   = 384,
  parameter int WAIT_TICKS = 520,
  parameter int BUSY_TICKS = 3900
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_cs,
  input  logic       cmd_sck,
  input  logic       cmd_sdi,
  input  logic       sled_off_in,
  output logic       laser_on,
  output logic       focus_mute,
  output logic       track_mute,
  output logic       sled_mute,
  output logic [1:0] spin_mode,
  output logic       search_pulse,
  output logic       bal_pulse,
  output logic       focus_ofs_busy,
  output logic       focus_ofs_on,
  output logic       track_ofs_busy,
  output logic       track_ofs_on
);
  localparam int TC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int WC_W = $clog2(WAIT_TICKS + 1);
  localparam int BC_W = $clog2(BUSY_TICKS + 1);

  localparam logic [7:0] C_RESET  = 8'h00;
  localparam logic [7:0] C_SEARCH = 8'h08;
  localparam logic [7:0] C_LASER  = 8'h94;
  localparam logic [7:0] C_FON    = 8'h95;
  localparam logic [7:0] C_FOFF   = 8'h96;
  localparam logic [7:0] C_SP8    = 8'h97;
  localparam logic [7:0] C_SP12   = 8'h98;
  localparam logic [7:0] C_SPOFF  = 8'h99;
  localparam logic [7:0] C_SLON   = 8'h9A;
  localparam logic [7:0] C_SLOFF  = 8'h9B;
  localparam logic [7:0] C_BAL    = 8'h9C;
  localparam logic [7:0] C_TOFF   = 8'h9D;
  localparam logic [7:0] C_TON    = 8'h9E;
  localparam logic [7:0] C_MASK_A = 8'hF0;
  localparam logic [7:0] C_MASK_B = 8'hF8;
  localparam logic [7:0] C_UNMASK = 8'hFF;

  logic [2:0]      cs_p, sck_p;
  logic [1:0]      sdi_p;
  logic [7:0]      shreg, cmd_reg, pend;
  logic [3:0]      bcnt;
  logic            pend_v, mask_on, sled_reg;
  logic [TC_W-1:0] tcnt;
  logic            cs_fall, sck_rise, tick, run, do_reset, latched;
  logic [1:0]      wait_ok, ofs_busy, ofs_on;

  assign cs_fall  = cs_p[2] & ~cs_p[1];
  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign tick     = (tcnt == TC_W'(TICK_DIV - 1));
  assign run      = tick & pend_v;
  assign do_reset = run && (pend == C_RESET);
  assign latched  = (cmd_reg == C_SEARCH) || (cmd_reg == C_BAL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p  <= '0;
      sck_p <= '0;
      sdi_p <= '0;
      tcnt  <= '0;
    end else begin
      cs_p  <= {cs_p[1:0], cmd_cs};
      sck_p <= {sck_p[1:0], cmd_sck};
      sdi_p <= {sdi_p[0], cmd_sdi};
      tcnt  <= tick ? '0 : tcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bcnt    <= '0;
      cmd_reg <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
      mask_on <= 1'b0;
    end else begin
      if (!cs_p[1]) bcnt <= '0;
      else if (sck_rise) begin
        shreg <= {sdi_p[1], shreg[7:1]};
        if (bcnt != 4'd15) bcnt <= bcnt + 4'd1;
      end
      if (tick) pend_v <= 1'b0;
      if (do_reset) begin
        cmd_reg <= '0;
        mask_on <= 1'b0;
      end
      if (cs_fall) begin
        if (bcnt == 4'd8) begin
          if (mask_on) begin
            if (shreg == C_UNMASK) mask_on <= 1'b0;
          end else if (shreg == C_MASK_A || shreg == C_MASK_B) begin
            mask_on <= 1'b1;
          end else if (shreg != C_UNMASK) begin
            cmd_reg <= shreg;
            pend    <= shreg;
            pend_v  <= 1'b1;
          end
        end else if (bcnt == 4'd0 && !mask_on && latched) begin
          pend   <= cmd_reg;
          pend_v <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      laser_on     <= 1'b0;
      focus_mute   <= 1'b1;
      track_mute   <= 1'b1;
      sled_reg     <= 1'b1;
      spin_mode    <= 2'b00;
      search_pulse <= 1'b0;
      bal_pulse    <= 1'b0;
    end else begin
      search_pulse <= run && (pend == C_SEARCH);
      bal_pulse    <= run && (pend == C_BAL);
      if (run) begin
        case (pend)
          C_RESET: begin
            laser_on   <= 1'b0;
            focus_mute <= 1'b1;
            track_mute <= 1'b1;
            sled_reg   <= 1'b1;
            spin_mode  <= 2'b00;
          end
          C_LASER: begin laser_on <= 1'b1; focus_mute <= 1'b0; end
          C_FON:   begin laser_on <= 1'b0; focus_mute <= 1'b0; end
          C_FOFF:  begin laser_on <= 1'b0; focus_mute <= 1'b1; end
          C_SP8:   spin_mode <= 2'b01;
          C_SP12:  spin_mode <= 2'b10;
          C_SPOFF: spin_mode <= 2'b00;
          C_SLON:  sled_reg <= 1'b0;
          C_SLOFF: sled_reg <= 1'b1;
          C_TOFF:  track_mute <= 1'b1;
          C_TON:   track_mute <= 1'b0;
          default: ;
        endcase
      end
    end

  assign sled_mute = sled_reg | sled_off_in;

  for (genvar g = 0; g < 2; g++) begin : g_ofs
    localparam logic [7:0] C_START = 8'h90 + 8'(2 * g);
    localparam logic [7:0] C_STOP  = 8'h91 + 8'(2 * g);
    logic [WC_W-1:0] wcnt;
    logic [BC_W-1:0] rcnt;
    logic            busy_q, on_q, restart, accept;

    assign wait_ok[g]  = (wcnt == WC_W'(WAIT_TICKS));
    assign ofs_busy[g] = busy_q;
    assign ofs_on[g]   = on_q;
    assign restart     = run && (pend == C_RESET || pend == C_STOP);
    assign accept      = run && (pend == C_START) && wait_ok[g] && !busy_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) wcnt <= '0;
      else if (restart) wcnt <= '0;
      else if (tick && !wait_ok[g]) wcnt <= wcnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        busy_q <= 1'b0;
        on_q   <= 1'b0;
        rcnt   <= '0;
      end else if (restart) begin
        busy_q <= 1'b0;
        on_q   <= 1'b0;
      end else if (accept) begin
        busy_q <= 1'b1;
        on_q   <= 1'b1;
        rcnt   <= '0;
      end else if (busy_q && tick) begin
        if (rcnt == BC_W'(BUSY_TICKS - 1)) busy_q <= 1'b0;
        else rcnt <= rcnt + 1'b1;
      end
  end

  assign focus_ofs_busy = ofs_busy[0];
  assign focus_ofs_on   = ofs_on[0];
  assign track_ofs_busy = ofs_busy[1];
  assign track_ofs_on   = ofs_on[1];
endmodule

// File: rtl/servo_cmd_rx_chk.sv
module servo_cmd_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       laser_on,
  input logic       track_mute,
  input logic [1:0] spin_mode,
  input logic       search_pulse,
  input logic       bal_pulse,
  input logic       sled_off_in,
  input logic       sled_mute,
  input logic [1:0] wait_ok,
  input logic [1:0] ofs_busy
);
  a_r3_laser_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(laser_on));
  a_r3_track_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(track_mute));
  a_r8_spin_legal: assert property (@(posedge clk) disable iff (!rst_n)
    spin_mode != 2'b11);
  a_r7_sled_forced: assert property (@(posedge clk) disable iff (!rst_n)
    sled_off_in |-> sled_mute);
  a_r13_search_single: assert property (@(posedge clk) disable iff (!rst_n)
    search_pulse |=> !search_pulse);
  a_r13_bal_single: assert property (@(posedge clk) disable iff (!rst_n)
    bal_pulse |=> !bal_pulse);
  a_r13_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(search_pulse && bal_pulse));
  a_r11_focus_rise_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ofs_busy[0]) |-> $past(wait_ok[0]));
  a_r11_track_rise_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ofs_busy[1]) |-> $past(wait_ok[1]));
  a_r12_focus_busy_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_busy[0] |-> wait_ok[0]);
  a_r12_track_busy_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_busy[1] |-> wait_ok[1]);
endmodule

bind servo_cmd_rx servo_cmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .laser_on(laser_on),
  .track_mute(track_mute), .spin_mode(spin_mode),
  .search_pulse(search_pulse), .bal_pulse(bal_pulse),
  .sled_off_in(sled_off_in), .sled_mute(sled_mute),
  .wait_ok(wait_ok), .ofs_busy(ofs_busy)
);

// File: tb/servo_cmd_rx_tb.sv
`timescale 1ns/1ps
module servo_cmd_rx_tb;
  localparam int DIV = 8;
  localparam int W   = 40;
  localparam int B   = 60;
  localparam int GAP = 40;

  logic clk = 0, rst_n = 0;
  logic cmd_cs = 0, cmd_sck = 0, cmd_sdi = 0, sled_off_in = 0;
  logic laser_on, focus_mute, track_mute, sled_mute, search_pulse, bal_pulse;
  logic focus_ofs_busy, focus_ofs_on, track_ofs_busy, track_ofs_on;
  logic [1:0] spin_mode;

  always #10 clk = ~clk;

  servo_cmd_rx #(.TICK_DIV(DIV), .WAIT_TICKS(W), .BUSY_TICKS(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_cs(cmd_cs), .cmd_sck(cmd_sck), .cmd_sdi(cmd_sdi),
    .sled_off_in(sled_off_in), .laser_on(laser_on), .focus_mute(focus_mute),
    .track_mute(track_mute), .sled_mute(sled_mute), .spin_mode(spin_mode),
    .search_pulse(search_pulse), .bal_pulse(bal_pulse),
    .focus_ofs_busy(focus_ofs_busy), .focus_ofs_on(focus_ofs_on),
    .track_ofs_busy(track_ofs_busy), .track_ofs_on(track_ofs_on));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: pin delays as queues, tick/wait/busy by tick counts
  int e_cnt, ntk, nb;
  int r_at[2], s_at[2];
  bit act_o[2], m_on[2], m_pv, m_mask;
  bit hc[$], hk[$], hd[$];
  logic [7:0] m_pend, m_cmd, acc;
  bit e_laser, e_fm, e_tm, e_sl, e_sp, e_bp;
  logic [1:0] e_spin;

  always @(posedge clk or negedge rst_n) begin : model
    bit tk, ex, fall, rise, om;
    logic [7:0] code, oc;
    int ontk;
    if (!rst_n) begin
      e_cnt = 0; ntk = 0; nb = 0; acc = 0; m_pv = 0; m_mask = 0;
      m_pend = 0; m_cmd = 0;
      e_laser = 0; e_fm = 1; e_tm = 1; e_sl = 1; e_sp = 0; e_bp = 0; e_spin = 0;
      for (int k = 0; k < 2; k++) begin r_at[k] = 0; s_at[k] = 0; act_o[k] = 0; m_on[k] = 0; end
      hc = '{0, 0, 0}; hk = '{0, 0, 0}; hd = '{0, 0};
    end else begin
      tk = (e_cnt % DIV) == DIV - 1;
      e_cnt++;
      ex = tk && m_pv; code = m_pend; om = m_mask; oc = m_cmd;
      fall = hc[2] && !hc[1];
      rise = hk[1] && !hk[2];
      ontk = ntk;
      if (tk) ntk++;
      e_sp = ex && code == 8'h08;
      e_bp = ex && code == 8'h9C;
      if (ex) begin
        case (code)
          8'h00: begin
            e_laser = 0; e_fm = 1; e_tm = 1; e_sl = 1; e_spin = 0; m_mask = 0; m_cmd = 0;
            for (int k = 0; k < 2; k++) begin act_o[k] = 0; m_on[k] = 0; r_at[k] = ntk; end
          end
          8'h94: begin e_laser = 1; e_fm = 0; end
          8'h95: begin e_laser = 0; e_fm = 0; end
          8'h96: begin e_laser = 0; e_fm = 1; end
          8'h97: e_spin = 2'b01;
          8'h98: e_spin = 2'b10;
          8'h99: e_spin = 2'b00;
          8'h9A: e_sl = 0;
          8'h9B: e_sl = 1;
          8'h9D: e_tm = 1;
          8'h9E: e_tm = 0;
          default: ;
        endcase
        for (int k = 0; k < 2; k++) begin
          if (code == 8'h90 + 8'(2 * k)) begin
            if (ontk - r_at[k] >= W && !(act_o[k] && ontk < s_at[k] + B)) begin
              act_o[k] = 1; s_at[k] = ntk; m_on[k] = 1;
            end
          end
          if (code == 8'h91 + 8'(2 * k)) begin act_o[k] = 0; m_on[k] = 0; r_at[k] = ntk; end
        end
      end
      if (tk) m_pv = 0;
      if (fall) begin
        if (nb == 8) begin
          if (om) begin
            if (acc == 8'hFF) m_mask = 0;
          end else if (acc == 8'hF0 || acc == 8'hF8) m_mask = 1;
          else if (acc != 8'hFF) begin m_cmd = acc; m_pend = acc; m_pv = 1; end
        end else if (nb == 0 && !om && (oc == 8'h08 || oc == 8'h9C)) begin
          m_pend = oc; m_pv = 1;
        end
      end
      if (!hc[1]) begin nb = 0; acc = 0; end
      else if (rise) begin
        if (nb < 8) acc[nb] = hd[1];
        if (nb < 15) nb++;
      end
      hc.push_front(cmd_cs); void'(hc.pop_back());
      hk.push_front(cmd_sck); void'(hk.pop_back());
      hd.push_front(cmd_sdi); void'(hd.pop_back());
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5 laser_on", laser_on, e_laser);
      chk("R5 focus_mute", focus_mute, e_fm);
      chk("R6 track_mute", track_mute, e_tm);
      chk("R7 sled_mute", sled_mute, e_sl | sled_off_in);
      chk("R8 spin_mode", spin_mode, e_spin);
      chk("R9 search_pulse", search_pulse, e_sp);
      chk("R9 bal_pulse", bal_pulse, e_bp);
      chk("R12 focus_ofs_busy", focus_ofs_busy, act_o[0] && ntk < s_at[0] + B);
      chk("R12 track_ofs_busy", track_ofs_busy, act_o[1] && ntk < s_at[1] + B);
      chk("R11 focus_ofs_on", focus_ofs_on, m_on[0]);
      chk("R11 track_ofs_on", track_ofs_on, m_on[1]);
    end
  end

  int sp_hi = 0, sp_rise = 0, bp_hi = 0, bp_rise = 0;
  logic sp_prev = 0, bp_prev = 0;
  always @(negedge clk) begin
    #1;
    if (search_pulse) sp_hi++;
    if (search_pulse && !sp_prev) sp_rise++;
    if (bal_pulse) bp_hi++;
    if (bal_pulse && !bp_prev) bp_rise++;
    sp_prev = search_pulse;
    bp_prev = bal_pulse;
  end

  task automatic send(input logic [7:0] b, input int nbits, input bit hold = 1);
    @(negedge clk) cmd_cs = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      cmd_sdi = b[i % 8];
      repeat (4) @(negedge clk);
      cmd_sck = 1;
      repeat (8) @(negedge clk);
      cmd_sck = 0;
      repeat (4) @(negedge clk);
    end
    cmd_cs = 0;
    if (hold) repeat (GAP) @(negedge clk);
  endtask

  task automatic bare_cs();
    @(negedge clk) cmd_cs = 1;
    repeat (8) @(negedge clk);
    cmd_cs = 0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R4 reset laser", laser_on, 0);
    chk("R4 reset focus_mute", focus_mute, 1);
    chk("R4 reset track_mute", track_mute, 1);
    chk("R4 reset sled_mute", sled_mute, 1);
    chk("R4 reset spin", spin_mode, 0);

    // R1 and R3: capture 0x94 and measure latency from enable fall
    send(8'h94, 8, 0);
    n = 0;
    while (!laser_on && n < 100) begin @(posedge clk); #1; n++; end
    chk("R3 latency in window", (n >= 4 && n <= DIV + 3), 1);
    repeat (GAP) @(negedge clk);
    chk("R1 laser_on after 0x94", laser_on, 1);
    chk("R5 focus unmuted", focus_mute, 0);

    // R2: short and long frames discarded
    send(8'h96, 7);
    settle();
    chk("R2 seven-bit frame ignored", laser_on, 1);
    send(8'h96, 9);
    settle();
    chk("R2 nine-bit frame ignored", laser_on, 1);

    send(8'h9E, 8); settle(); chk("R6 track unmute", track_mute, 0);
    send(8'h9D, 8); settle(); chk("R6 track mute", track_mute, 1);
    send(8'h9E, 8);

    send(8'h9A, 8); settle(); chk("R7 sled on", sled_mute, 0);
    sled_off_in = 1; settle(); chk("R7 external sled off", sled_mute, 1);
    sled_off_in = 0; settle(); chk("R7 external released", sled_mute, 0);

    send(8'h97, 8); settle(); chk("R8 small disc", spin_mode, 1);
    send(8'h98, 8); settle(); chk("R8 large disc", spin_mode, 2);
    send(8'h99, 8); settle(); chk("R8 spindle off", spin_mode, 0);

    // R9: latched start and clearing
    send(8'h08, 8); chk("R9 search fired", sp_rise, 1);
    bare_cs(); chk("R9 search refired", sp_rise, 2);
    send(8'hFE, 8);
    bare_cs(); chk("R9 cleared by 0xFE", sp_rise, 2);
    send(8'h9C, 8); chk("R9 balance fired", bp_rise, 1);

    // R10: masking
    send(8'hF0, 8);
    bare_cs(); chk("R10 masked refire ignored", bp_rise, 1);
    send(8'h96, 8); settle(); chk("R10 masked byte ignored", laser_on, 1);
    send(8'hFF, 8);
    send(8'h96, 8); settle(); chk("R10 unmasked byte runs", laser_on, 0);
    chk("R5 focus muted by 0x96", focus_mute, 1);
    send(8'hF8, 8);
    send(8'h95, 8); settle(); chk("R10 second mask byte", focus_mute, 1);
    send(8'hFF, 8);
    send(8'h95, 8); settle(); chk("R5 focus on laser off", focus_mute, 0);
    send(8'hFE, 8);

    // R11 and R12: offset adjust timing
    send(8'h91, 8);
    send(8'h90, 8); settle();
    chk("R11 early start rejected", focus_ofs_busy, 0);
    chk("R11 early start not applied", focus_ofs_on, 0);
    repeat (400) @(negedge clk);
    send(8'h90, 8); settle();
    chk("R11 start accepted", focus_ofs_busy, 1);
    repeat (300) @(negedge clk);
    chk("R12 still busy", focus_ofs_busy, 1);
    repeat (250) @(negedge clk);
    chk("R12 busy cleared", focus_ofs_busy, 0);
    chk("R12 applied stays", focus_ofs_on, 1);
    send(8'h91, 8); settle();
    chk("R12 off clears applied", focus_ofs_on, 0);
    send(8'h92, 8); settle();
    chk("R11 track start accepted", track_ofs_busy, 1);

    // R4: reset command
    send(8'h94, 8);
    send(8'h00, 8); settle();
    chk("R4 cmd reset laser", laser_on, 0);
    chk("R4 cmd reset focus_mute", focus_mute, 1);
    chk("R4 cmd reset track_mute", track_mute, 1);
    chk("R4 cmd reset track busy", track_ofs_busy, 0);
    chk("R4 cmd reset track applied", track_ofs_on, 0);
    send(8'h92, 8); settle();
    chk("R11 start after reset cmd rejected", track_ofs_busy, 0);

    chk("R13 search pulse width", sp_hi, sp_rise);
    chk("R13 balance pulse width", bp_hi, bp_rise);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule